// File: doc/BRIEF.md
# Iterative Carry-Save Mantissa Multiplier

This block multiplies two unsigned 48-bit mantissas over several clock cycles. A pulse on `start` captures both operands and the rounding choice. The block then retires one 8-bit digit of the multiplier per cycle, starting with the least significant digit. For each digit it forms a partial product, the multiplicand times that digit, and folds it into a running result. The running result is kept as a pair of sum and carry vectors, and one row of 3:2 compressors does the folding, so no carry runs the length of the word during the iterations.

After the last digit, one carry-propagate addition merges the two vectors into the full 96-bit product. The block keeps the upper 48 bits of that product and can round them. A host starts an operation, waits for the one-cycle `done` pulse and reads `prodHi`. Sign and exponent handling belong to the surrounding unit.

Top module: `mantissa_csa_mul`

## Requirements
- R1: After reset, `done` is low and `prodHi` is all zeros.
- R2: A `start` sampled high while the block is idle begins an operation. `done` is high during the cycle that follows the seventh rising edge after the edge that sampled `start`. In general this is edge W/DIGIT+1.
- R3: `done` is high for exactly one cycle per operation.
- R4: With rounding off, `prodHi` equals bits 95..48 of the exact 96-bit unsigned product `mcand * mplier`.
- R5: With rounding on, `prodHi` equals bits 95..48 of the exact product plus bit 47 of that product. The rounded value always fits in 48 bits.
- R6: `roundEn` is sampled only on the edge that accepts `start`. A later change of `roundEn` does not affect the result of the operation in progress.
- R7: While an operation is in progress, `start` is ignored, and so are changes on `mcand` and `mplier`. The pending result and the `done` timing are unaffected.
- R8: `prodHi` keeps its value from the end of one operation until the next operation completes, whatever the inputs do in between.
- R9: Zero and all-ones operands give exact results. This includes the largest product, (2^48-1)^2.
- R10: The multiplier is consumed 8 bits per iteration, low digit first, and is shifted right end-off. No multiplier bits remain when the merge step runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when sampled high while idle |
| mcand | input | 48 | Multiplicand mantissa, unsigned |
| mplier | input | 48 | Multiplier mantissa, unsigned |
| roundEn | input | 1 | Selects rounding of the upper half, sampled with `start` |
| prodHi | output | 48 | Upper half of the product, rounded if selected |
| done | output | 1 | One-cycle pulse when `prodHi` holds a new result |

## Verification
The bench builds the block with its default parameters: a 48-bit mantissa and 8-bit digits, which gives six iterations. With these values the vectors can place a nonzero digit only in the lowest or only in the highest multiplier position. They can also push an all-ones square through every compressor bit of the 96-bit pair, and set up a product whose only set bit is bit 47, the round position. The same widths make the seven-edge latency and the mid-operation disturbance windows concrete cycle numbers that the bench checks at the ports.

// File: rtl/mantissa_csa_pkg.sv
package mantissa_csa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_MERGE = 2'd2
  } mulState_t;

  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // fold one digit, shift operands
    logic merge;  // carry-propagate merge and store result
  } mulStrobe_t;

endpackage

// File: rtl/mantissa_csa_ctrl.sv
module mantissa_csa_ctrl
  import mantissa_csa_pkg::*;
#(
  parameter int W     = 48,
  parameter int DIGIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strb,
  output logic       done
);

  localparam int ITERS = W / DIGIT;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  mulState_t     stateQ, stateD;
  logic [CW-1:0] cntQ;
  logic          doneQ;

  always_comb begin
    stateD     = stateQ;
    strb.load  = 1'b0;
    strb.step  = 1'b0;
    strb.merge = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateD    = ST_RUN;
        end
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (cntQ == LAST) stateD = ST_MERGE;
      end
      ST_MERGE: begin
        strb.merge = 1'b1;
        stateD     = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.merge;
      if (strb.load)      cntQ <= '0;
      else if (strb.step) cntQ <= cntQ + CW'(1);
    end
  end

  assign done = doneQ;

  // R3: a completion pulse never lasts two cycles
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: completion follows the merge state directly
  assert_done_after_merge_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(stateQ) == ST_MERGE);

  // R2: iterations advance one per cycle without a gap
  assert_iter_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && cntQ != LAST) |=>
      (stateQ == ST_RUN && cntQ == $past(cntQ) + CW'(1)));

  // R7: at most one strobe at a time, so a busy start cannot reload
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step, strb.merge}));

endmodule

// File: rtl/mantissa_csa_dp.sv
module mantissa_csa_dp
  import mantissa_csa_pkg::*;
#(
  parameter int W     = 48,
  parameter int DIGIT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulStrobe_t   strb,
  input  logic [W-1:0] mcandIn,
  input  logic [W-1:0] mplierIn,
  input  logic         roundIn,
  output logic [W-1:0] prodHi
);

  localparam int PW = 2 * W;

  logic [PW-1:0] mcandQ;
  logic [W-1:0]  mplQ;
  logic [PW-1:0] sumQ, carQ;
  logic          rndQ;
  logic [W-1:0]  prodHiQ;

  logic [DIGIT-1:0] digit;
  logic [PW-1:0]    partial;
  logic [PW-1:0]    sumNext, majBits, carNext;
  logic [PW-1:0]    merged;
  logic [W:0]       rounded;

  // digit selection: sum of shifted multiplicand copies for set digit bits
  function automatic logic [PW-1:0] digitProduct(input logic [PW-1:0] m,
                                                 input logic [DIGIT-1:0] d);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < DIGIT; i++) begin
      if (d[i]) acc = acc + (m << i);
    end
    return acc;
  endfunction

  assign digit   = mplQ[DIGIT-1:0];
  assign partial = digitProduct(mcandQ, digit);

  // one 3:2 compressor per bit of the redundant pair
  for (genvar b = 0; b < PW; b++) begin : g_csa
    assign sumNext[b] = sumQ[b] ^ carQ[b] ^ partial[b];
    assign majBits[b] = (sumQ[b] & carQ[b]) | (sumQ[b] & partial[b]) |
                        (carQ[b] & partial[b]);
  end
  assign carNext = {majBits[PW-2:0], 1'b0};

  // final carry-propagate merge and optional rounding of the upper half
  assign merged  = sumQ + carQ;
  assign rounded = {1'b0, merged[PW-1:W]} + {{W{1'b0}}, rndQ & merged[W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ  <= '0;
      mplQ    <= '0;
      sumQ    <= '0;
      carQ    <= '0;
      rndQ    <= 1'b0;
      prodHiQ <= '0;
    end else begin
      if (strb.load) begin
        mcandQ <= PW'(mcandIn);
        mplQ   <= mplierIn;
        sumQ   <= '0;
        carQ   <= '0;
        rndQ   <= roundIn;
      end else if (strb.step) begin
        mcandQ <= mcandQ << DIGIT;
        mplQ   <= mplQ >> DIGIT;
        sumQ   <= sumNext;
        carQ   <= carNext;
      end
      if (strb.merge) prodHiQ <= rounded[W-1:0];
    end
  end

  assign prodHi = prodHiQ;

  // R4: every compression step preserves the value of the pair plus the digit product
  assert_csa_conserve_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (sumQ + carQ) == ($past(sumQ) + $past(carQ) + $past(partial)));

  // R10: multiplier fully shifted out by the time of the merge
  assert_mplier_consumed_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |-> mplQ == '0);

  // R5: rounding never carries out of the upper half
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |-> !rounded[W]);

  // R8: the result register changes only on a merge
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.merge |=> $stable(prodHiQ));

endmodule

// File: rtl/mantissa_csa_mul.sv
module mantissa_csa_mul
  import mantissa_csa_pkg::*;
#(
  parameter int W     = 48,
  parameter int DIGIT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic         roundEn,
  output logic [W-1:0] prodHi,
  output logic         done
);

  mulStrobe_t strb;

  mantissa_csa_ctrl #(.W(W), .DIGIT(DIGIT)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  mantissa_csa_dp #(.W(W), .DIGIT(DIGIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mcandIn  (mcand),
    .mplierIn (mplier),
    .roundIn  (roundEn),
    .prodHi   (prodHi)
  );

endmodule

// File: tb/test_mantissa_csa_mul.sv
module test_mantissa_csa_mul;

  localparam int W = 48;
  localparam int NV = 10;

  localparam logic [W-1:0] VA [NV] = '{
    48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF,
    48'h8000_0000_0000, 48'h1234_5678_9ABC, 48'hFEDC_BA98_7654,
    48'hA5A5_A5A5_A5A5, 48'h0000_0000_0001, 48'h8000_0000_0000,
    48'h8000_0000_0000 };
  localparam logic [W-1:0] VB [NV] = '{
    48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF,
    48'h8000_0000_0000, 48'h0000_0000_00FF, 48'hFF00_0000_0000,
    48'h5A5A_5A5A_5A5A, 48'hC000_0000_0001, 48'h0000_0000_0001,
    48'h0000_0000_0001 };
  localparam logic VR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
                               1'b0, 1'b1, 1'b0};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         roundEn = 1'b0;
  logic [W-1:0] prodHi;
  logic         done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  mantissa_csa_mul i_mantissa_csa_mul (
    .clk(clk), .rstN(rstN), .start(start), .mcand(mcand),
    .mplier(mplier), .roundEn(roundEn), .prodHi(prodHi), .done(done)
  );

  function automatic logic [W-1:0] expectHi(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic r);
    logic [2*W-1:0] full;
    full = (2*W)'(a) * (2*W)'(b);
    return full[2*W-1:W] + {{(W-1){1'b0}}, r & full[W-1]};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // disturb: raise start with other operands and flipped rounding mid-run (R6, R7)
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic r, input bit disturb, input string req);
    logic early;
    early = 1'b0;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b; roundEn = r;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k < 7 && done) early = 1'b1;
      if (disturb && k == 2) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 48'h1; roundEn = ~r;
      end else if (disturb && k == 4) begin
        start = 1'b0;
      end
    end
    chk("R2 done timing", {47'd0, done & ~early}, 48'd1);
    chk(req, prodHi, expectHi(a, b, r));
    @(negedge clk);
    chk("R3 done pulse", {47'd0, done}, 48'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done at reset", {47'd0, done}, 48'd0);
    chk("R1 prodHi at reset", prodHi, 48'd0);
    rstN = 1'b1;

    // R4 / R5 / R9 / R10: vector table
    for (int i = 0; i < NV; i++) begin
      runOp(VA[i], VB[i], VR[i], 1'b0, VR[i] ? "R5 rounded product" : "R4 product");
    end

    // R9: explicit all-ones square, R4 form
    runOp(48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R9 all-ones");
    // R10: only highest digit of multiplier set
    runOp(48'h0000_0000_0001, 48'h0100_0000_0000, 1'b0, 1'b0, "R10 top digit");

    // R6 / R7: start, operands and rounding disturbed during compute
    runOp(48'h8000_0000_0000, 48'h0000_0000_0001, 1'b1, 1'b1, "R6 round sampled at start");
    runOp(48'hA5A5_A5A5_A5A5, 48'h5A5A_5A5A_5A5A, 1'b0, 1'b1, "R7 busy start ignored");
    // the mid-run start must not have queued another result
    repeat (10) @(negedge clk);
    chk("R7 no extra done", {47'd0, done}, 48'd0);

    // R8: result holds while inputs wander without start
    held = prodHi;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      mcand = mcand + 48'h1357; mplier = ~mplier; roundEn = ~roundEn;
    end
    chk("R8 prodHi held", prodHi, held);

    // R1: reset during an operation returns to reset state
    @(negedge clk);
    start = 1'b1; mcand = 48'hFFFF_FFFF_FFFF; mplier = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 prodHi after mid reset", prodHi, 48'd0);
    chk("R1 done after mid reset", {47'd0, done}, 48'd0);
    rstN = 1'b1;
    runOp(48'h0000_0000_0003, 48'h0000_0000_0005, 1'b0, 1'b0, "R4 after reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule